// File: doc/BRIEF.md
# Nibble-Scrambling Read Transformer

This block turns a raw 16-bit word into a scrambled read result, one word per clock. Each read carries a small descriptor beside the raw word. The descriptor holds four 2-bit nibble selectors, a 2-bit rotate amount and two mask-enable flags. Three selectors fill the upper three output nibbles with chosen source nibbles. The fourth selector picks the source for the low nibble, and that nibble alone is rotated left. The assembled word can then be XORed with one key, and after that ANDed with a second key and inverted.

The two 16-bit keys live inside the block. They are loaded through a small write port that has a per-bit lane mask. The descriptor values come from outside. The result is registered and comes out one clock after the read request, with a valid strobe.

Top module: `nibscr_top`

## Requirements
- R1: Selector j sits in `sel_i[2j+1:2j]`. Selector 0 fills output bits 15:12, selector 1 fills bits 11:8 and selector 2 fills bits 7:4. A selector value k takes source bits `raw_i[4k+3:4k]`.
- R2: Selector 3 chooses the source nibble for output bits 3:0. That nibble alone is rotated left by `rot_i` (0 to 3) places, and the bits that leave at the top come back in at the bottom.
- R3: When `flag_i[0]` is 1, the assembled word is XORed with the XOR key.
- R4: When `flag_i[1]` is 1, the word is ANDed with the NAND key and then inverted. This step uses the word after the XOR step.
- R5: During reset both keys are 0x0000, `out_valid_o` is 0 and `out_data_o` is 0x0000.
- R6: A key write happens when `key_we_i` is 1. `key_idx_i` = 0 picks the XOR key and 1 picks the NAND key. Only the bits where `key_mask_i` is 1 take `key_data_i`; the other bits keep their value. A read in the same cycle as the write still sees the old key, and reads from the next cycle on see the new key.
- R7: A read presented with `rd_valid_i` gives its result on `out_data_o` at the next rising edge, with `out_valid_o` high for that one cycle. In cycles without a read, `out_valid_o` is 0 and `out_data_o` keeps its last value.
- R8: Selectors may repeat a source nibble or leave one out. The block makes no uniqueness check and still applies R1 and R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_valid_i | input | 1 | Read request this cycle |
| raw_i | input | 16 | Raw source word |
| sel_i | input | 8 | Four 2-bit nibble selectors; selector j in bits 2j+1:2j |
| rot_i | input | 2 | Left rotate amount for the low nibble |
| flag_i | input | 2 | Bit 0 enables the XOR step, bit 1 enables the NAND step |
| key_we_i | input | 1 | Key write strobe |
| key_idx_i | input | 1 | Key to write: 0 for XOR, 1 for NAND |
| key_data_i | input | 16 | Key write data |
| key_mask_i | input | 16 | Per-bit write enable |
| out_valid_o | output | 1 | Result valid |
| out_data_o | output | 16 | Registered result |

## Verification
The bench builds the block with its default parameters: four nibbles of four bits each. At that size the selector space has only 256 patterns and the rotate field only 4 values. The bench therefore sweeps all 1024 permute-and-rotate cases on a raw word whose nibbles all differ, so every source nibble can be told apart in the output, and that sweep includes every pattern with repeated or missing nibbles. It then runs every flag combination against loaded keys, partial-mask key writes, and a key write that lands in the same cycle as a read.

// File: rtl/nibscr_pkg.sv
package nibscr_pkg;
  localparam int unsigned DEF_NIB_W   = 4;
  localparam int unsigned DEF_NIB_CNT = 4;
  localparam int unsigned KEY_CNT     = 2;
  localparam int unsigned KEY_XOR     = 0;
  localparam int unsigned KEY_NAND    = 1;
  localparam int unsigned FLAG_XOR    = 0;
  localparam int unsigned FLAG_NAND   = 1;
  localparam int unsigned FLAG_W      = 2;
endpackage

// File: rtl/nibscr_keyreg.sv
module nibscr_keyreg #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] wmask_i,
  output logic [DATA_W-1:0] key_o
);
  logic [DATA_W-1:0] key_q;
  logic [DATA_W-1:0] key_next;

  always_comb key_next = (key_q & ~wmask_i) | (wdata_i & wmask_i);

  always_ff @(posedge clk) begin
    if (!rst_n)    key_q <= '0;
    else if (we_i) key_q <= key_next;
  end

  assign key_o = key_q;

  // R6: bits outside the lane mask keep their value across a write
  p_unmasked_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (((key_o ^ $past(key_o)) & ~$past(wmask_i)) == '0));
  // R6: bits inside the lane mask take the written data
  p_masked_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> ((key_o & $past(wmask_i)) == ($past(wdata_i) & $past(wmask_i))));
  // R6: no write means no change
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(key_o));
endmodule

// File: rtl/nibscr_permute.sv
module nibscr_permute #(
  parameter int unsigned NIB_W   = 4,
  parameter int unsigned NIB_CNT = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NIB_W*NIB_CNT-1:0]           raw_i,
  input  logic [$clog2(NIB_CNT)*NIB_CNT-1:0] sel_i,
  input  logic [$clog2(NIB_W)-1:0]           rot_i,
  output logic [NIB_W*NIB_CNT-1:0]           word_o
);
  localparam int unsigned DATA_W = NIB_W * NIB_CNT;
  localparam int unsigned SEL_W  = $clog2(NIB_CNT);
  localparam int unsigned ROT_W  = $clog2(NIB_W);

  function automatic logic [NIB_W-1:0] pick_nib(input logic [DATA_W-1:0] w,
                                                input logic [SEL_W-1:0] s);
    return w[s*NIB_W +: NIB_W];
  endfunction

  function automatic logic [NIB_W-1:0] rotl_nib(input logic [NIB_W-1:0] n,
                                                input logic [ROT_W-1:0] r);
    logic [2*NIB_W-1:0] dbl;
    dbl = {n, n} << r;
    return dbl[2*NIB_W-1:NIB_W];
  endfunction

  logic [NIB_W-1:0] low_pre;
  logic [NIB_W-1:0] low_post;

  for (genvar j = 0; j < NIB_CNT; j++) begin : g_slot
    logic [NIB_W-1:0] picked;
    assign picked = pick_nib(raw_i, sel_i[j*SEL_W +: SEL_W]);
    if (j == NIB_CNT - 1) begin : g_low
      assign low_pre  = picked;
      assign low_post = rotl_nib(picked, rot_i);
      assign word_o[NIB_W-1:0] = low_post;
    end else begin : g_high
      assign word_o[(NIB_CNT-1-j)*NIB_W +: NIB_W] = picked;
    end
  end

  // R2: rotation only moves bits, so the count of ones is kept
  p_rot_keeps_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(low_post) == $countones(low_pre));
  // R2: a zero rotate leaves the low nibble as picked
  p_rot_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rot_i == '0) |-> (word_o[NIB_W-1:0] == low_pre));
endmodule

// File: rtl/nibscr_mask.sv
module nibscr_mask
  import nibscr_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] word_i,
  input  logic [FLAG_W-1:0] flag_i,
  input  logic [DATA_W-1:0] key_xor_i,
  input  logic [DATA_W-1:0] key_nand_i,
  output logic [DATA_W-1:0] word_o
);
  function automatic logic [DATA_W-1:0] xor_step(input logic [DATA_W-1:0] w,
                                                 input logic en,
                                                 input logic [DATA_W-1:0] k);
    return en ? (w ^ k) : w;
  endfunction

  function automatic logic [DATA_W-1:0] nand_step(input logic [DATA_W-1:0] w,
                                                  input logic en,
                                                  input logic [DATA_W-1:0] k);
    return en ? ~(w & k) : w;
  endfunction

  logic [DATA_W-1:0] after_xor;

  assign after_xor = xor_step(word_i, flag_i[FLAG_XOR], key_xor_i);
  assign word_o    = nand_step(after_xor, flag_i[FLAG_NAND], key_nand_i);

  // R3: XOR alone differs from the input by exactly the key
  p_xor_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_i == 2'b01) |-> ((word_o ^ word_i) == key_xor_i));
  // R4: a zero NAND key forces all ones whatever came before
  p_nand_zero_key_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_i[FLAG_NAND] && key_nand_i == '0) |-> (word_o == '1));
  // R3 R4: with both flags clear the word passes unchanged
  p_pass_through_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_i == '0) |-> (word_o == word_i));
endmodule

// File: rtl/nibscr_top.sv
module nibscr_top
  import nibscr_pkg::*;
#(
  parameter int unsigned NIB_W   = DEF_NIB_W,
  parameter int unsigned NIB_CNT = DEF_NIB_CNT
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               rd_valid_i,
  input  logic [NIB_W*NIB_CNT-1:0]           raw_i,
  input  logic [$clog2(NIB_CNT)*NIB_CNT-1:0] sel_i,
  input  logic [$clog2(NIB_W)-1:0]           rot_i,
  input  logic [1:0]                         flag_i,
  input  logic                               key_we_i,
  input  logic [$clog2(KEY_CNT)-1:0]         key_idx_i,
  input  logic [NIB_W*NIB_CNT-1:0]           key_data_i,
  input  logic [NIB_W*NIB_CNT-1:0]           key_mask_i,
  output logic                               out_valid_o,
  output logic [NIB_W*NIB_CNT-1:0]           out_data_o
);
  localparam int unsigned DATA_W = NIB_W * NIB_CNT;

  logic [DATA_W-1:0] key_val [KEY_CNT];
  logic [DATA_W-1:0] permuted;
  logic [DATA_W-1:0] masked;
  logic              valid_q;
  logic [DATA_W-1:0] data_q;

  for (genvar k = 0; k < KEY_CNT; k++) begin : g_key
    logic sel_we;
    assign sel_we = key_we_i && (key_idx_i == k);
    nibscr_keyreg #(.DATA_W(DATA_W)) u_key (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (sel_we),
      .wdata_i (key_data_i),
      .wmask_i (key_mask_i),
      .key_o   (key_val[k])
    );
  end

  nibscr_permute #(.NIB_W(NIB_W), .NIB_CNT(NIB_CNT)) u_perm (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  (raw_i),
    .sel_i  (sel_i),
    .rot_i  (rot_i),
    .word_o (permuted)
  );

  nibscr_mask #(.DATA_W(DATA_W)) u_mask (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_i     (permuted),
    .flag_i     (flag_i),
    .key_xor_i  (key_val[KEY_XOR]),
    .key_nand_i (key_val[KEY_NAND]),
    .word_o     (masked)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= rd_valid_i;
      if (rd_valid_i) data_q <= masked;
    end
  end

  assign out_valid_o = valid_q;
  assign out_data_o  = data_q;

  // R7: one result strobe per read, one cycle later
  p_valid_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_i |=> out_valid_o);
  p_no_spurious_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid_i |=> !out_valid_o);
  // R7: output holds when no read was presented
  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid_i |=> $stable(out_data_o));
endmodule

// File: tb/nibscr_top_test.sv
module nibscr_top_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_valid_i = 1'b0;
  logic [15:0] raw_i = '0;
  logic [7:0]  sel_i = '0;
  logic [1:0]  rot_i = '0;
  logic [1:0]  flag_i = '0;
  logic        key_we_i = 1'b0;
  logic [0:0]  key_idx_i = '0;
  logic [15:0] key_data_i = '0;
  logic [15:0] key_mask_i = '0;
  logic        out_valid_o;
  logic [15:0] out_data_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nibscr_top uut (
    .clk(clk), .rst_n(rst_n), .rd_valid_i(rd_valid_i), .raw_i(raw_i),
    .sel_i(sel_i), .rot_i(rot_i), .flag_i(flag_i), .key_we_i(key_we_i),
    .key_idx_i(key_idx_i), .key_data_i(key_data_i), .key_mask_i(key_mask_i),
    .out_valid_o(out_valid_o), .out_data_o(out_data_o)
  );

  function automatic int model(int raw, int sel, int rot, int flg, int kx, int kn);
    int r = 0;
    int n;
    for (int j = 0; j < 3; j++) begin
      n = (raw / (1 << (4 * ((sel / (1 << (2 * j))) % 4)))) % 16;
      r = r + n * (1 << (12 - 4 * j));
    end
    n = (raw / (1 << (4 * ((sel / 64) % 4)))) % 16;
    r = r + ((n * (1 << rot)) % 16) + (n / (1 << (4 - rot)));
    if (flg % 2 == 1) r = r ^ kx;
    if (flg >= 2) r = 16'hFFFF ^ (r & kn);
    return r & 16'hFFFF;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_read(int raw, int sel, int rot, int flg);
    @(negedge clk);
    rd_valid_i = 1'b1;
    raw_i = raw[15:0]; sel_i = sel[7:0]; rot_i = rot[1:0]; flag_i = flg[1:0];
    @(negedge clk);
    rd_valid_i = 1'b0;
  endtask

  task automatic write_key(int idx, int data, int mask);
    @(negedge clk);
    key_we_i = 1'b1; key_idx_i = idx[0:0];
    key_data_i = data[15:0]; key_mask_i = mask[15:0];
    @(negedge clk);
    key_we_i = 1'b0;
  endtask

  initial begin
    int kx = 0;
    int kn = 0;
    int last;
    repeat (3) @(negedge clk);
    // R5: reset state
    check("R5 valid in reset", out_valid_o, 0);
    check("R5 data in reset", out_data_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R5 valid after reset", out_valid_o, 0);

    // R5: keys start at zero: XOR with zero key is a pass-through
    do_read(16'h1234, 8'h1B, 0, 1);
    check("R5 zero xor key", out_data_o, 16'h1234);
    check("R7 valid strobe", out_valid_o, 1);
    // R5: NAND with zero key gives all ones
    do_read(16'h1234, 8'h1B, 0, 2);
    check("R5 zero nand key", out_data_o, 16'hFFFF);

    // R1 R2 R8: full permute and rotate sweep, raw nibbles all distinct
    for (int sv = 0; sv < 256; sv++) begin
      for (int rt = 0; rt < 4; rt++) begin
        bit rep;
        rep = 0;
        for (int a = 0; a < 4; a++)
          for (int b = a + 1; b < 4; b++)
            if (((sv >> (2*a)) & 3) == ((sv >> (2*b)) & 3)) rep = 1;
        do_read(16'hD3A6, sv, rt, 0);
        check(rep ? "R8 repeated selectors" : "R1 R2 permute rotate",
              out_data_o, model(16'hD3A6, sv, rt, 0, 0, 0));
      end
    end

    // R6: partial-mask write of the XOR key
    write_key(0, 16'hFFFF, 16'h00FF);
    kx = 16'h00FF;
    do_read(16'h0000, 8'h1B, 0, 1);
    check("R6 masked xor load", out_data_o, kx);
    write_key(0, 16'h5A00, 16'hFF00);
    kx = 16'h5AFF;
    do_read(16'h0000, 8'h1B, 0, 1);
    check("R6 second masked load keeps low", out_data_o, kx);
    write_key(1, 16'hF0F0, 16'hFFFF);
    kn = 16'hF0F0;
    do_read(16'h0000, 8'h1B, 0, 1);
    check("R6 nand write leaves xor key", out_data_o, kx);

    // R3 R4: flags against loaded keys
    for (int f = 0; f < 4; f++) begin
      for (int rt = 0; rt < 4; rt++) begin
        do_read(16'h7C19, 8'h4E, rt, f);
        check(f >= 2 ? "R4 nand after xor" : "R3 xor step",
              out_data_o, model(16'h7C19, 8'h4E, rt, f, kx, kn));
      end
    end

    // R6: write and read in the same cycle sees the old key
    @(negedge clk);
    key_we_i = 1'b1; key_idx_i = 1'b0; key_data_i = 16'h0000; key_mask_i = 16'hFFFF;
    rd_valid_i = 1'b1; raw_i = 16'h0000; sel_i = 8'h1B; rot_i = 0; flag_i = 2'b01;
    @(negedge clk);
    key_we_i = 1'b0; rd_valid_i = 1'b0;
    check("R6 same-cycle read uses old key", out_data_o, kx);
    kx = 0;
    do_read(16'h0000, 8'h1B, 0, 1);
    check("R6 next read uses new key", out_data_o, 0);

    // R7: idle cycles hold data, valid low
    do_read(16'hBEEF, 8'h1B, 3, 0);
    last = model(16'hBEEF, 8'h1B, 3, 0, 0, 0);
    check("R7 result", out_data_o, last);
    @(negedge clk);
    raw_i = 16'h0000;
    @(negedge clk);
    check("R7 valid low when idle", out_valid_o, 0);
    check("R7 data held when idle", out_data_o, last);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule